// File: doc/BRIEF.md
# DMA Channel Register Front End

This block holds the software-visible state of one bus-master DMA channel. A processor reaches it through a 32-bit, word-wide slave port. The port decodes a 16-byte window of four registers:

| Index | Register |
|-------|----------|
| 0 | control/status word |
| 1 | current transfer address |
| 2 | byte count |
| 3 | high-address base |

The data mover and the peripheral sit outside the block. They talk to it through three signals: a level interrupt input from the peripheral, a transfer-done strobe that carries a byte length, and a one-cycle reset pulse sent back to the peripheral.

A write to the control word applies a fixed set of side effects before the value is stored:

- The upper nibble is forced to a version code.
- The reset bit, the drain bit and an all-zero value are handled in that order of priority.
- A cleared interrupt-enable bit silences the interrupt line.

A write to the address register marks the channel as loaded. Each completed transfer advances the address by its length and raises the pending flag.

The bus fabric passes on only the byte offset inside the window, so an instance may sit at any base address. Reads are combinational from the stored registers.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control word reads 0xA0000000, registers 1 to 3 read zero, and both `irq_out` and `dev_rst_pulse` are low.
- R2: A write takes effect only when `bus_sel`, `bus_we` and all four byte enables are high and `bus_addr[1:0]` is 00. Any other write leaves every register unchanged. The register index is `bus_addr[3:2]`, and a read returns the stored word of that index.
- R3: After a control write, the stored bits [31:28] are 0xA and bits [27:0] equal the written bits, except where R5 alters them. Bit 8 (transfer direction, toward memory) is stored as written.
- R4: A control write with bit 7 (peripheral reset) set drives `dev_rst_pulse` high for exactly the one cycle that follows the write. It stores the drain bit exactly as written.
- R5: If bit 7 of a control write is clear and bit 6 (drain) is set, bit 6 is stored as 0. If the whole written value is zero, the stored word is 0xA0000040.
- R6: A control write with bit 4 (interrupt enable) clear forces `irq_out` low in the next cycle. This holds even if the peripheral interrupt rises in the same cycle.
- R7: A write to register 1 stores the address and sets control bit 26 (address loaded).
- R8: A rising `dev_irq_in` sets control bit 0 (interrupt pending) and raises `irq_out` in the next cycle. A falling `dev_irq_in` clears both.
- R9: A `xfer_done` strobe adds `xfer_len` to register 1 and sets control bit 0, and it leaves `irq_out` unchanged.
- R10: When a register-1 write and `xfer_done` occur in the same cycle, register 1 takes the written value and control bit 0 is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Slave port access strobe |
| bus_we | input | 1 | Write when high |
| bus_addr | input | 4 | Byte offset inside the register window |
| bus_be | input | 4 | Byte enables; only full-word writes act |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| dev_irq_in | input | 1 | Level interrupt from the peripheral |
| xfer_done | input | 1 | One-cycle transfer-complete strobe |
| xfer_len | input | 16 | Bytes moved by the completed transfer |
| irq_out | output | 1 | Interrupt request to the processor |
| dev_rst_pulse | output | 1 | One-cycle reset to the peripheral |

## Verification
The hardest situations to reach from the ports are those where two sources update the same state in one clock. One is an address write landing in the same cycle as a transfer-done strobe. The other is a control write that clears the enable bit while the peripheral interrupt is already high. The bench puts the strobe in place before it issues the bus write, so both fall on one edge. For the second case it raises the peripheral interrupt first and then writes a control word with the enable bit clear. Each case is then read back through the slave port and checked on `irq_out`.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int DW = 32;

  // control word bit positions
  localparam int CTL_PEND   = 0;
  localparam int CTL_IEN    = 4;
  localparam int CTL_DRAIN  = 6;
  localparam int CTL_DEVRST = 7;
  localparam int CTL_LOADED = 26;

  // register indices that carry behaviour
  localparam int IDX_CTL  = 0;
  localparam int IDX_ADDR = 1;

  // apply the write-time shaping rules of the control word
  function automatic logic [DW-1:0] shape_ctl(input logic [DW-1:0] wv,
                                              input logic [3:0]    ver);
    logic [DW-1:0] r;
    r = wv;
    if (wv[CTL_DEVRST]) begin
      r = wv;
    end else if (wv[CTL_DRAIN]) begin
      r[CTL_DRAIN] = 1'b0;
    end else if (wv == '0) begin
      r[CTL_DRAIN] = 1'b1;
    end
    r[DW-1:DW-4] = ver;
    return r;
  endfunction
endpackage

// File: rtl/dma_chan_rstsync.sv
module dma_chan_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter logic [3:0] VERSION = 4'hA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          set_loaded,
  input  logic          set_pend,
  input  logic          clr_pend,
  output logic [DW-1:0] ctl_q,
  output logic          dev_rst_q
);
  logic [DW-1:0] ctl_d;
  logic          ctl_en;
  logic          dev_rst_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d = shape_ctl(wdata, VERSION);
      if (set_pend) ctl_d[CTL_PEND] = 1'b1;
    end else begin
      if (set_loaded) ctl_d[CTL_LOADED] = 1'b1;
      if (set_pend)      ctl_d[CTL_PEND] = 1'b1;
      else if (clr_pend) ctl_d[CTL_PEND] = 1'b0;
    end
    ctl_en    = wr_en | set_loaded | set_pend | clr_pend;
    dev_rst_d = wr_en & wdata[CTL_DEVRST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= {VERSION, {(DW-4){1'b0}}};
      dev_rst_q <= 1'b0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      dev_rst_q <= dev_rst_d;
    end
  end
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_irq,
  input  logic ien_clear,
  output logic rise,
  output logic fall,
  output logic irq_q
);
  logic prev_q;
  logic irq_d;

  always_comb begin
    rise  = dev_irq & ~prev_q;
    fall  = ~dev_irq & prev_q;
    irq_d = irq_q;
    if (rise)      irq_d = 1'b1;
    if (fall)      irq_d = 1'b0;
    if (ien_clear) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= dev_irq;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/dma_chan_words.sv
module dma_chan_words
  import dma_chan_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int LEN_W = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DW-1:0]              wdata,
  input  logic                       done,
  input  logic [LEN_W-1:0]           len,
  output logic [NREG-1:1][DW-1:0]    words_q
);
  for (genvar g = 1; g < NREG; g++) begin : g_word
    logic [DW-1:0] q;
    logic [DW-1:0] d;
    logic          en;

    if (g == IDX_ADDR) begin : g_addr
      always_comb begin
        en = 1'b0;
        d  = q;
        if (wr_en && wr_idx == IDX_W'(g)) begin
          en = 1'b1;
          d  = wdata;
        end else if (done) begin
          en = 1'b1;
          d  = q + DW'(len);
        end
      end
    end else begin : g_plain
      always_comb begin
        en = wr_en && (wr_idx == IDX_W'(g));
        d  = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign words_q[g] = q;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int         NREG    = 4,
  parameter int         LEN_W   = 16,
  parameter logic [3:0] VERSION = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              dev_irq_in,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              irq_out,
  output logic              dev_rst_pulse
);
  localparam int IDX_W = $clog2(NREG);

  logic                    rst_sync_n;
  logic                    wr_ok;
  logic [IDX_W-1:0]        idx;
  logic                    wr_ctl;
  logic                    wr_adr;
  logic                    ien_clear;
  logic                    irq_rise;
  logic                    irq_fall;
  logic [DW-1:0]           ctl_q;
  logic [NREG-1:1][DW-1:0] words_q;

  dma_chan_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    idx       = bus_addr[IDX_W+1:2];
    wr_ok     = bus_sel & bus_we & (&bus_be) & (bus_addr[1:0] == 2'b00);
    wr_ctl    = wr_ok && (idx == IDX_W'(IDX_CTL));
    wr_adr    = wr_ok && (idx == IDX_W'(IDX_ADDR));
    ien_clear = wr_ctl & ~bus_wdata[CTL_IEN];
  end

  dma_chan_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .dev_irq   (dev_irq_in),
    .ien_clear (ien_clear),
    .rise      (irq_rise),
    .fall      (irq_fall),
    .irq_q     (irq_out)
  );

  dma_chan_ctl #(.VERSION(VERSION)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_ctl),
    .wdata      (bus_wdata),
    .set_loaded (wr_adr),
    .set_pend   (irq_rise | xfer_done),
    .clr_pend   (irq_fall),
    .ctl_q      (ctl_q),
    .dev_rst_q  (dev_rst_pulse)
  );

  dma_chan_words #(.NREG(NREG), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_words (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_ok),
    .wr_idx  (idx),
    .wdata   (bus_wdata),
    .done    (xfer_done),
    .len     (xfer_len),
    .words_q (words_q)
  );

  always_comb begin
    bus_rdata = ctl_q;
    for (int i = 1; i < NREG; i++) begin
      if (idx == IDX_W'(i)) bus_rdata = words_q[i];
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int         LEN_W   = 16,
  parameter logic [3:0] VERSION = 4'hA
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic [3:0]       bus_be,
  input logic [31:0]      bus_wdata,
  input logic             dev_irq_in,
  input logic             xfer_done,
  input logic [LEN_W-1:0] xfer_len,
  input logic             irq_out,
  input logic             dev_rst_pulse,
  input logic [31:0]      ctl_q,
  input logic [31:0]      addr_q
);
  logic full_wr;
  logic ctl_wr;
  logic adr_wr;
  assign full_wr = bus_sel && bus_we && bus_be == 4'hF && bus_addr[1:0] == 2'b00;
  assign ctl_wr  = full_wr && bus_addr[3:2] == 2'd0;
  assign adr_wr  = full_wr && bus_addr[3:2] == 2'd1;

  // R3
  ver_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[31:28] == VERSION);

  // R4
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[7]) |=> dev_rst_pulse);

  // R4
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst_pulse && !(ctl_wr && bus_wdata[7])) |=> !dev_rst_pulse);

  // R6
  ien_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !bus_wdata[4]) |=> !irq_out);

  // R7
  loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adr_wr |=> ctl_q[26]);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dev_irq_in) && !(ctl_wr && !bus_wdata[4])) |=> irq_out);

  // R9
  done_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !adr_wr) |=> addr_q == $past(addr_q) + 32'($past(xfer_len)));

  // R10
  done_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> ctl_q[0]);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.LEN_W(LEN_W), .VERSION(VERSION)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .bus_sel       (bus_sel),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_be        (bus_be),
  .bus_wdata     (bus_wdata),
  .dev_irq_in    (dev_irq_in),
  .xfer_done     (xfer_done),
  .xfer_len      (xfer_len),
  .irq_out       (irq_out),
  .dev_rst_pulse (dev_rst_pulse),
  .ctl_q         (ctl_q),
  .addr_q        (words_q[1])
);

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        dev_irq_in = 1'b0;
  logic        xfer_done = 1'b0;
  logic [15:0] xfer_len = 16'h0;
  logic        irq_out;
  logic        dev_rst_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma_chan_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dev_irq_in(dev_irq_in), .xfer_done(xfer_done),
    .xfer_len(xfer_len), .irq_out(irq_out), .dev_rst_pulse(dev_rst_pulse)
  );

  // {index[1:0], byte enables[3:0], write data, expected readback}
  localparam logic [69:0] VEC [11] = '{
    {2'd0, 4'hF, 32'h0000_0010, 32'hA000_0010},  // R3
    {2'd0, 4'hF, 32'h0000_0000, 32'hA000_0040},  // R5 zero
    {2'd0, 4'hF, 32'h0000_00C0, 32'hA000_00C0},  // R4 drain kept
    {2'd0, 4'hF, 32'h0000_0050, 32'hA000_0010},  // R5 drain cleared
    {2'd0, 4'hF, 32'hFFFF_FFFF, 32'hAFFF_FFFF},  // R3 nibble forced
    {2'd0, 4'hF, 32'h5000_0100, 32'hA000_0100},  // R3 direction bit
    {2'd2, 4'hF, 32'h1234_5678, 32'h1234_5678},  // R2
    {2'd2, 4'h3, 32'hDEAD_BEEF, 32'h1234_5678},  // R2 narrow ignored
    {2'd3, 4'hF, 32'hF000_0000, 32'hF000_0000},  // R2
    {2'd3, 4'h8, 32'h0000_FFFF, 32'hF000_0000},  // R2 narrow ignored
    {2'd1, 4'hF, 32'h0000_1000, 32'h0000_1000}   // R7
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [3:0] be, input logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = off; bus_be = be; bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; xfer_done = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] val);
    bus_addr = {idx, 2'b00};
    #1 val = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 ctl", v, 32'hA000_0000);
    rd(2'd1, v); check("R1 addr", v, 32'h0);
    rd(2'd2, v); check("R1 count", v, 32'h0);
    rd(2'd3, v); check("R1 base", v, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    check("R1 pulse", {31'b0, dev_rst_pulse}, 32'h0);

    for (int i = 0; i < 11; i++) begin
      wr({VEC[i][69:68], 2'b00}, VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][69:68], v);
      check($sformatf("R2/R3/R5 vector %0d", i), v, VEC[i][31:0]);
    end

    // R2 misaligned offset ignored
    wr(4'h9, 4'hF, 32'h0BAD_0BAD);
    rd(2'd2, v); check("R2 misaligned", v, 32'h1234_5678);

    // R7 loaded flag
    wr(4'h0, 4'hF, 32'h0000_0010);
    wr(4'h4, 4'hF, 32'h0000_2000);
    rd(2'd0, v); check("R7 loaded", v, 32'hA400_0010);

    // R4 pulse width
    wr(4'h0, 4'hF, 32'h0000_0080);
    check("R4 pulse high", {31'b0, dev_rst_pulse}, 32'h1);
    @(negedge clk);
    check("R4 pulse low", {31'b0, dev_rst_pulse}, 32'h0);

    // R8 interrupt follows peripheral edges
    wr(4'h0, 4'hF, 32'h0000_0010);
    dev_irq_in = 1'b1;
    @(negedge clk);
    check("R8 irq up", {31'b0, irq_out}, 32'h1);
    rd(2'd0, v); check("R8 pend set", v, 32'hA000_0011);
    dev_irq_in = 1'b0;
    @(negedge clk);
    check("R8 irq down", {31'b0, irq_out}, 32'h0);
    rd(2'd0, v); check("R8 pend clr", v, 32'hA000_0010);

    // R6 enable clear beats a same-cycle rise
    @(negedge clk);
    dev_irq_in = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'h0; bus_be = 4'hF; bus_wdata = 32'h0000_0100;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check("R6 irq forced low", {31'b0, irq_out}, 32'h0);
    rd(2'd0, v); check("R6 ctl stored", v, 32'hA000_0101);
    dev_irq_in = 1'b0;
    @(negedge clk);

    // R9 transfer done advances address
    wr(4'h0, 4'hF, 32'h0000_0010);
    wr(4'h4, 4'hF, 32'h0000_0100);
    @(negedge clk);
    xfer_done = 1'b1; xfer_len = 16'h0024;
    @(negedge clk);
    xfer_done = 1'b0;
    rd(2'd1, v); check("R9 addr", v, 32'h0000_0124);
    rd(2'd0, v); check("R9 pend", v & 32'h1, 32'h1);
    check("R9 irq unchanged", {31'b0, irq_out}, 32'h0);

    // R10 bus write wins over a same-cycle done strobe
    wr(4'h0, 4'hF, 32'h0000_0010);
    xfer_len = 16'h0008;
    @(negedge clk);
    xfer_done = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_be = 4'hF; bus_wdata = 32'h0000_0500;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; xfer_done = 1'b0;
    rd(2'd1, v); check("R10 addr", v, 32'h0000_0500);
    rd(2'd0, v); check("R10 pend", v, 32'hA400_0011);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule